// File: doc/BRIEF.md
# Stack-Top Word Cache with Spill and Refill

This block keeps the topmost words of a downward-growing program stack in a local array of 64 entries of 32 bits each. The array is not a register file with names. It is a moving view onto stack memory, covering the words from the stack pointer upward. Every access gives a word offset from the stack pointer. Offsets inside the view are served from the array. Offsets beyond it are passed on to backing memory as a single-word transaction.

Three frame commands move or repair the view. Allocate lowers the stack pointer by a word count. Before it does, it writes out the modified entries that are pushed past the top of the view. Release raises the stack pointer and drops the entries that leave the view. Restore reloads the lowest words of the view from memory, skipping entries that already hold data. The word at offset 0 is the accumulator and is shown on its own output. Backing memory uses a request/acknowledge port that moves one word per acknowledged cycle. While a multi-cycle sequence runs, a busy flag blocks new commands.

The controller is a five-state machine:
- `ST_IDLE` accepts commands and serves hits.
- `ST_FILL` performs a single-word refill for a read miss.
- `ST_FAR` performs an access beyond the view.
- `ST_SPILL` walks the displaced entries on allocate.
- `ST_RESTORE` walks the entries to reload.

Transitions:
- `ST_IDLE` moves to `ST_FILL` on a read of an invalid in-view entry.
- `ST_IDLE` moves to `ST_FAR` on any access at offset 64 or more.
- `ST_IDLE` moves to `ST_SPILL` on a non-zero allocate.
- `ST_IDLE` moves to `ST_RESTORE` on a non-zero restore.
- `ST_FILL` and `ST_FAR` return to `ST_IDLE` on the memory acknowledge.
- `ST_SPILL` and `ST_RESTORE` return to `ST_IDLE` when their last entry has been handled.

Top module: `stack_cache`

## Requirements
- R1: After reset, `sp_out` equals the `SP_INIT` parameter, `busy` is low, and every entry is invalid and clean, so `acc_valid` is low.
- R2: Command codes on `cmd_op` are: 0 read, 1 write, 2 allocate, 3 release, 4 restore. A write at an offset below 64 stores the word locally and marks it valid and dirty, with no memory traffic. A read of a valid entry at an offset below 64 raises `rsp_valid` with the data in the same cycle the command is presented, with no memory traffic.
- R3: A read of an invalid entry at an offset below 64 issues one memory read at byte address `sp_out + 4*offset`. The word is returned on `rsp_data` in the acknowledge cycle, and the entry becomes valid and clean.
- R4: A read or write at an offset of 64 or more issues one memory access at `sp_out + 4*offset` and leaves the array unchanged. A read returns the memory word in the acknowledge cycle.
- R5: Allocate of n words examines the displaced entries at offsets 63 down to 64-min(n,64), highest address first. Each one that is both valid and dirty is written to its own address, one word per acknowledge. At the end, `sp_out` decreases by 4n and the displaced entries are invalid.
- R6: During allocate, displaced entries that are clean or invalid cause no memory write. Allocate of 0 changes nothing.
- R7: Release of n words raises `sp_out` by 4n with no memory traffic. The entries that were at offsets below min(n,64) become invalid, and their data is dropped.
- R8: Restore of n words visits offsets min(n,64)-1 down to 0. It reads each invalid entry from memory and marks it valid and clean. Valid entries keep their contents and cause no memory traffic.
- R9: `acc_valid` and `acc_data` always show the valid bit and the data of the entry at offset 0 of the current stack pointer.
- R10: `busy` is high in every state but idle. A command presented while `busy` is high is ignored. A memory request keeps its address, direction and write data unchanged until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 3 | Command code (see R2) |
| cmd_arg | input | ARGW | Word offset for read/write, word count for frame commands |
| cmd_wdata | input | DW | Write data |
| busy | output | 1 | Sequence in progress; commands ignored |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | DW | Read data |
| acc_valid | output | 1 | Offset-0 entry valid |
| acc_data | output | DW | Offset-0 entry data |
| sp_out | output | AW | Stack pointer, byte address |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | DW | Memory write data |
| mem_ack | input | 1 | Memory acknowledge; completes the request |
| mem_rdata | input | DW | Memory read data, valid with acknowledge |

## Verification
The two actions that can share a clock edge are the final step of an allocate spill and the frame move. On the edge that accepts the last write-back, the stack pointer drops and the displaced entries are invalidated. The bench provokes this with an allocate whose topmost displaced entry is dirty, and with a full 64-word allocate over a completely dirty array. It judges the result by the order and contents of the memory writes, then by the new `sp_out` and accumulator, and then by refills that must return the spilled words. A second overlap is tested by presenting a write while a spill is still running and confirming later that the word was never stored.

// File: rtl/stack_cache_pkg.sv
package stack_cache_pkg;

    typedef enum logic [2:0] {
        OP_READ    = 3'd0,
        OP_WRITE   = 3'd1,
        OP_ALLOC   = 3'd2,
        OP_RELEASE = 3'd3,
        OP_RESTORE = 3'd4
    } sc_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL,
        ST_FAR,
        ST_SPILL,
        ST_RESTORE
    } sc_state_e;

endpackage

// File: rtl/stack_cache_store.sv
module stack_cache_store #(
    parameter int DEPTH = 64,
    parameter int DW    = 32,
    parameter int IW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IW-1:0]    wr_idx,
    input  logic [DW-1:0]    wr_data,
    input  logic             wr_dirty,
    input  logic             inv_en,
    input  logic [DEPTH-1:0] inv_mask,
    input  logic [IW-1:0]    rd_idx,
    output logic [DW-1:0]    rd_data,
    output logic             rd_valid,
    output logic             rd_dirty,
    input  logic [IW-1:0]    acc_idx,
    output logic [DW-1:0]    acc_data,
    output logic             acc_valid
);

    logic [DW-1:0]    words_q [DEPTH];
    logic [DEPTH-1:0] vld_q;
    logic [DEPTH-1:0] drt_q;

    // Data words carry no reset: valid bits guard every use.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            words_q[wr_idx] <= wr_data;
        end
    end

    // Per-entry state; a write in the same cycle overrides invalidation.
    for (genvar g = 0; g < DEPTH; g++) begin : g_flag
        logic hit_wr;
        assign hit_wr = wr_en && (wr_idx == IW'(g));
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q[g] <= 1'b0;
                drt_q[g] <= 1'b0;
            end else if (hit_wr) begin
                vld_q[g] <= 1'b1;
                drt_q[g] <= wr_dirty;
            end else if (inv_en && inv_mask[g]) begin
                vld_q[g] <= 1'b0;
                drt_q[g] <= 1'b0;
            end
        end
    end

    assign rd_data   = words_q[rd_idx];
    assign rd_valid  = vld_q[rd_idx];
    assign rd_dirty  = drt_q[rd_idx];
    assign acc_data  = words_q[acc_idx];
    assign acc_valid = vld_q[acc_idx];

endmodule

// File: rtl/stack_cache_window.sv
module stack_cache_window #(
    parameter int DEPTH = 64,
    parameter int IW    = $clog2(DEPTH)
) (
    input  logic [IW-1:0]    sp_lo,
    input  logic [IW:0]      off_lo,
    input  logic [IW:0]      off_hi,
    output logic [DEPTH-1:0] mask
);

    // Entry g holds stack offset (g - sp_lo) mod DEPTH; select offsets in [off_lo, off_hi).
    for (genvar g = 0; g < DEPTH; g++) begin : g_sel
        logic [IW-1:0] rel;
        assign rel     = IW'(g) - sp_lo;
        assign mask[g] = ({1'b0, rel} >= off_lo) && ({1'b0, rel} < off_hi);
    end

endmodule

// File: rtl/stack_cache_ctrl.sv
module stack_cache_ctrl
    import stack_cache_pkg::*;
#(
    parameter int          DEPTH   = 64,
    parameter int          DW      = 32,
    parameter int          AW      = 32,
    parameter int          ARGW    = 8,
    parameter logic [31:0] SP_INIT = 32'h0000_2000,
    parameter int          IW      = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    input  sc_op_e          cmd_op,
    input  logic [ARGW-1:0] cmd_arg,
    input  logic [DW-1:0]   cmd_wdata,
    input  logic            ent_valid,
    input  logic            ent_dirty,
    input  logic [DW-1:0]   ent_data,
    input  logic            mem_ack,
    input  logic [DW-1:0]   mem_rdata,
    output logic            busy,
    output logic            rsp_valid,
    output logic [DW-1:0]   rsp_data,
    output logic [AW-1:0]   sp_q,
    output logic [IW-1:0]   look_off,
    output logic            wr_en,
    output logic [DW-1:0]   wr_data,
    output logic            wr_dirty,
    output logic            inv_en,
    output logic [IW:0]     inv_lo,
    output logic [IW:0]     inv_hi,
    output logic            mem_req,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata
);

    localparam logic [ARGW:0] DEPTH_A = (ARGW+1)'(DEPTH);
    localparam logic [IW:0]   DEPTH_M = (IW+1)'(DEPTH);

    sc_state_e       state, nxt;
    sc_op_e          op_q;
    logic [ARGW-1:0] arg_q;
    logic [DW-1:0]   wdata_q;
    logic [IW-1:0]   cnt_q;
    logic [IW-1:0]   lo_q;

    logic            accept;
    logic            in_win;
    logic [IW:0]     span;
    logic            step;
    logic [AW-1:0]   arg_bytes_in;
    logic [AW-1:0]   arg_bytes_q;
    logic [AW-1:0]   cnt_bytes;

    assign accept       = cmd_valid && (state == ST_IDLE);
    assign in_win       = {1'b0, cmd_arg} < DEPTH_A;
    assign span         = in_win ? cmd_arg[IW:0] : DEPTH_M;
    assign arg_bytes_in = {{(AW-ARGW-2){1'b0}}, cmd_arg, 2'b00};
    assign arg_bytes_q  = {{(AW-ARGW-2){1'b0}}, arg_q, 2'b00};
    assign cnt_bytes    = {{(AW-IW-2){1'b0}}, cnt_q, 2'b00};
    assign busy         = (state != ST_IDLE);

    // One entry finished in a walk: either nothing to move, or the move is acknowledged.
    always_comb begin
        step = 1'b0;
        unique case (state)
            ST_SPILL:   step = (ent_valid && ent_dirty) ? mem_ack : 1'b1;
            ST_RESTORE: step = ent_valid ? 1'b1 : mem_ack;
            default:    step = 1'b0;
        endcase
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (cmd_valid) begin
                    unique case (cmd_op)
                        OP_READ: begin
                            if (!in_win)         nxt = ST_FAR;
                            else if (!ent_valid) nxt = ST_FILL;
                        end
                        OP_WRITE: begin
                            if (!in_win) nxt = ST_FAR;
                        end
                        OP_ALLOC: begin
                            if (span != '0) nxt = ST_SPILL;
                        end
                        OP_RESTORE: begin
                            if (span != '0) nxt = ST_RESTORE;
                        end
                        default: nxt = ST_IDLE;
                    endcase
                end
            end
            ST_FILL, ST_FAR: begin
                if (mem_ack) nxt = ST_IDLE;
            end
            ST_SPILL: begin
                if (step && (cnt_q == lo_q)) nxt = ST_IDLE;
            end
            ST_RESTORE: begin
                if (step && (cnt_q == '0)) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Sequencing registers and stack pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q    <= AW'(SP_INIT);
            op_q    <= OP_READ;
            arg_q   <= '0;
            wdata_q <= '0;
            cnt_q   <= '0;
            lo_q    <= '0;
        end else if (accept) begin
            op_q    <= cmd_op;
            arg_q   <= cmd_arg;
            wdata_q <= cmd_wdata;
            if (cmd_op == OP_ALLOC) begin
                cnt_q <= '1;
                lo_q  <= IW'(DEPTH_M - span);
            end
            if (cmd_op == OP_RESTORE) begin
                cnt_q <= IW'(span - 1'b1);
                lo_q  <= '0;
            end
            if (cmd_op == OP_RELEASE) begin
                sp_q <= sp_q + arg_bytes_in;
            end
        end else if ((state == ST_SPILL) && step) begin
            if (cnt_q == lo_q) sp_q  <= sp_q - arg_bytes_q;
            else               cnt_q <= cnt_q - 1'b1;
        end else if ((state == ST_RESTORE) && step && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Outputs per state.
    always_comb begin
        rsp_valid = 1'b0;
        rsp_data  = '0;
        look_off  = cmd_arg[IW-1:0];
        wr_en     = 1'b0;
        wr_data   = '0;
        wr_dirty  = 1'b0;
        inv_en    = 1'b0;
        inv_lo    = '0;
        inv_hi    = '0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = sp_q + cnt_bytes;
        mem_wdata = '0;
        unique case (state)
            ST_IDLE: begin
                if (cmd_valid) begin
                    unique case (cmd_op)
                        OP_READ: begin
                            if (in_win && ent_valid) begin
                                rsp_valid = 1'b1;
                                rsp_data  = ent_data;
                            end
                        end
                        OP_WRITE: begin
                            if (in_win) begin
                                wr_en    = 1'b1;
                                wr_data  = cmd_wdata;
                                wr_dirty = 1'b1;
                            end
                        end
                        OP_RELEASE: begin
                            inv_en = 1'b1;
                            inv_hi = span;
                        end
                        default: ;
                    endcase
                end
            end
            ST_FILL: begin
                look_off = arg_q[IW-1:0];
                mem_req  = 1'b1;
                mem_addr = sp_q + arg_bytes_q;
                if (mem_ack) begin
                    wr_en     = 1'b1;
                    wr_data   = mem_rdata;
                    rsp_valid = 1'b1;
                    rsp_data  = mem_rdata;
                end
            end
            ST_FAR: begin
                look_off  = arg_q[IW-1:0];
                mem_req   = 1'b1;
                mem_we    = (op_q == OP_WRITE);
                mem_addr  = sp_q + arg_bytes_q;
                mem_wdata = wdata_q;
                if (mem_ack && (op_q == OP_READ)) begin
                    rsp_valid = 1'b1;
                    rsp_data  = mem_rdata;
                end
            end
            ST_SPILL: begin
                look_off = cnt_q;
                if (ent_valid && ent_dirty) begin
                    mem_req   = 1'b1;
                    mem_we    = 1'b1;
                    mem_wdata = ent_data;
                end
                if (step && (cnt_q == lo_q)) begin
                    inv_en = 1'b1;
                    inv_lo = {1'b0, lo_q};
                    inv_hi = DEPTH_M;
                end
            end
            ST_RESTORE: begin
                look_off = cnt_q;
                if (!ent_valid) begin
                    mem_req = 1'b1;
                    if (mem_ack) begin
                        wr_en   = 1'b1;
                        wr_data = mem_rdata;
                    end
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/stack_cache.sv
module stack_cache
    import stack_cache_pkg::*;
#(
    parameter int          DEPTH   = 64,
    parameter int          DW      = 32,
    parameter int          AW      = 32,
    parameter int          ARGW    = 8,
    parameter logic [31:0] SP_INIT = 32'h0000_2000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    input  logic [2:0]      cmd_op,
    input  logic [ARGW-1:0] cmd_arg,
    input  logic [DW-1:0]   cmd_wdata,
    output logic            busy,
    output logic            rsp_valid,
    output logic [DW-1:0]   rsp_data,
    output logic            acc_valid,
    output logic [DW-1:0]   acc_data,
    output logic [AW-1:0]   sp_out,
    output logic            mem_req,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    input  logic            mem_ack,
    input  logic [DW-1:0]   mem_rdata
);

    localparam int IW = $clog2(DEPTH);

    sc_op_e           op_in;
    logic [AW-1:0]    sp_q;
    logic [IW-1:0]    sp_lo;
    logic [IW-1:0]    look_off;
    logic [IW-1:0]    ent_idx;
    logic             ent_valid;
    logic             ent_dirty;
    logic [DW-1:0]    ent_data;
    logic             wr_en;
    logic [DW-1:0]    wr_data;
    logic             wr_dirty;
    logic             inv_en;
    logic [IW:0]      inv_lo;
    logic [IW:0]      inv_hi;
    logic [DEPTH-1:0] inv_mask;

    assign op_in   = sc_op_e'(cmd_op);
    assign sp_lo   = sp_q[IW+1:2];
    assign ent_idx = sp_lo + look_off;
    assign sp_out  = sp_q;

    stack_cache_ctrl #(
        .DEPTH(DEPTH), .DW(DW), .AW(AW), .ARGW(ARGW), .SP_INIT(SP_INIT), .IW(IW)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_valid(cmd_valid),
        .cmd_op   (op_in),
        .cmd_arg  (cmd_arg),
        .cmd_wdata(cmd_wdata),
        .ent_valid(ent_valid),
        .ent_dirty(ent_dirty),
        .ent_data (ent_data),
        .mem_ack  (mem_ack),
        .mem_rdata(mem_rdata),
        .busy     (busy),
        .rsp_valid(rsp_valid),
        .rsp_data (rsp_data),
        .sp_q     (sp_q),
        .look_off (look_off),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .wr_dirty (wr_dirty),
        .inv_en   (inv_en),
        .inv_lo   (inv_lo),
        .inv_hi   (inv_hi),
        .mem_req  (mem_req),
        .mem_we   (mem_we),
        .mem_addr (mem_addr),
        .mem_wdata(mem_wdata)
    );

    stack_cache_window #(.DEPTH(DEPTH), .IW(IW)) u_window (
        .sp_lo (sp_lo),
        .off_lo(inv_lo),
        .off_hi(inv_hi),
        .mask  (inv_mask)
    );

    stack_cache_store #(.DEPTH(DEPTH), .DW(DW), .IW(IW)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (ent_idx),
        .wr_data  (wr_data),
        .wr_dirty (wr_dirty),
        .inv_en   (inv_en),
        .inv_mask (inv_mask),
        .rd_idx   (ent_idx),
        .rd_data  (ent_data),
        .rd_valid (ent_valid),
        .rd_dirty (ent_dirty),
        .acc_idx  (sp_lo),
        .acc_data (acc_data),
        .acc_valid(acc_valid)
    );

endmodule

// File: rtl/stack_cache_checker.sv
module stack_cache_checker #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          rsp_valid,
    input logic [AW-1:0] sp_out,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_wdata,
    input logic          mem_ack
);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R10

    AST_WDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && !mem_ack) |=> $stable(mem_wdata)); // R5

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req); // R2

    AST_SP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mem_req && !mem_ack) |=> $stable(sp_out)); // R5

    AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00)); // R4

    AST_RSP_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && busy) |-> mem_ack); // R3

endmodule

bind stack_cache stack_cache_checker #(.AW(AW), .DW(DW)) u_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .rsp_valid(rsp_valid),
    .sp_out   (sp_out),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .mem_ack  (mem_ack)
);

// File: tb/stack_cache_test.sv
`timescale 1ns/1ps
module stack_cache_test;

    localparam int          DEPTH = 64;
    localparam int          DW    = 32;
    localparam int          AW    = 32;
    localparam int          ARGW  = 8;
    localparam logic [31:0] SP0   = 32'h0000_2000;
    localparam int          MW    = 4096;

    localparam logic [2:0] C_RD = 3'd0, C_WR = 3'd1, C_AL = 3'd2, C_RL = 3'd3, C_RS = 3'd4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cmd_valid = 1'b0;
    logic [2:0]      cmd_op = '0;
    logic [ARGW-1:0] cmd_arg = '0;
    logic [DW-1:0]   cmd_wdata = '0;
    logic            busy, rsp_valid, acc_valid;
    logic [DW-1:0]   rsp_data, acc_data;
    logic [AW-1:0]   sp_out;
    logic            mem_req, mem_we;
    logic [AW-1:0]   mem_addr;
    logic [DW-1:0]   mem_wdata;
    logic            mem_ack = 1'b0;
    logic [DW-1:0]   mem_rdata = '0;

    always #10 clk = ~clk;

    stack_cache #(.DEPTH(DEPTH), .DW(DW), .AW(AW), .ARGW(ARGW), .SP_INIT(SP0)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_arg(cmd_arg), .cmd_wdata(cmd_wdata), .busy(busy),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .acc_valid(acc_valid),
        .acc_data(acc_data), .sp_out(sp_out), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Scoreboard queues.
    logic        xm_we   [$];
    logic [31:0] xm_addr [$];
    logic [31:0] xm_data [$];
    string       xm_req  [$];
    logic [31:0] xr_data [$];
    string       xr_req  [$];

    // Backing memory, reference image and cache model by word address.
    logic [31:0] mem     [MW];
    logic [31:0] ref_mem [MW];
    bit          cval    [MW];
    bit          cdirty  [MW];
    logic [31:0] cdata   [MW];
    int          spw;

    function automatic int wi(input int w);
        return w % MW;
    endfunction

    task automatic push_mem(input logic we, input int w, input logic [31:0] d, input string req);
        xm_we.push_back(we);
        xm_addr.push_back(32'(wi(w)) << 2);
        xm_data.push_back(d);
        xm_req.push_back(req);
    endtask

    task automatic push_rsp(input logic [31:0] d, input string req);
        xr_data.push_back(d);
        xr_req.push_back(req);
    endtask

    // Memory responder: acknowledge with 0 or 1 cycles of wait, alternating.
    int wait_c = 0;
    int lat = 0;
    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack = 1'b0;
        end else if (mem_req) begin
            if (wait_c < lat) begin
                wait_c++;
            end else begin
                wait_c = 0;
                lat = 1 - lat;
                mem_ack = 1'b1;
                mem_rdata = mem[mem_addr[13:2]];
                if (mem_we) mem[mem_addr[13:2]] = mem_wdata;
                if (xm_we.size() == 0) begin
                    chk(1'b0, "R6", "unexpected memory access", mem_addr, 32'h0);
                end else begin
                    logic        e_we;
                    logic [31:0] e_ad, e_d;
                    string       e_r;
                    e_we = xm_we.pop_front();
                    e_ad = xm_addr.pop_front();
                    e_d  = xm_data.pop_front();
                    e_r  = xm_req.pop_front();
                    chk(mem_we == e_we, e_r, "memory direction", 32'(mem_we), 32'(e_we));
                    chk(mem_addr == e_ad, e_r, "memory address", mem_addr, e_ad);
                    if (e_we) chk(mem_wdata == e_d, e_r, "memory write data", mem_wdata, e_d);
                end
            end
        end
    end

    // Response monitor: samples midway between the falling and rising edges.
    always @(negedge clk) begin
        #5;
        if (rst_n && rsp_valid) begin
            if (xr_data.size() == 0) begin
                chk(1'b0, "R2", "unexpected response", rsp_data, 32'h0);
            end else begin
                logic [31:0] e;
                string       r;
                e = xr_data.pop_front();
                r = xr_req.pop_front();
                chk(rsp_data == e, r, "read data", rsp_data, e);
            end
        end
    end

    // Driver: applies one command and predicts its effects.
    task automatic issue(input logic [2:0] op, input int arg, input logic [31:0] wd);
        int m;
        @(negedge clk);
        while (busy) @(negedge clk);
        m = (arg < DEPTH) ? arg : DEPTH;
        case (op)
            C_RD: begin
                int w;
                w = wi(spw + arg);
                if (arg >= DEPTH) begin
                    push_mem(1'b0, w, 32'h0, "R4");
                    push_rsp(ref_mem[w], "R4");
                end else if (cval[w]) begin
                    push_rsp(cdata[w], "R2");
                end else begin
                    push_mem(1'b0, w, 32'h0, "R3");
                    push_rsp(ref_mem[w], "R3");
                    cval[w] = 1'b1; cdirty[w] = 1'b0; cdata[w] = ref_mem[w];
                end
            end
            C_WR: begin
                int w;
                w = wi(spw + arg);
                if (arg >= DEPTH) begin
                    push_mem(1'b1, w, wd, "R4");
                    ref_mem[w] = wd;
                end else begin
                    cval[w] = 1'b1; cdirty[w] = 1'b1; cdata[w] = wd;
                end
            end
            C_AL: begin
                for (int o = DEPTH - 1; o >= DEPTH - m; o--) begin
                    int w;
                    w = wi(spw + o);
                    if (cval[w] && cdirty[w]) begin
                        push_mem(1'b1, w, cdata[w], "R5");
                        ref_mem[w] = cdata[w];
                    end
                    cval[w] = 1'b0; cdirty[w] = 1'b0;
                end
                spw = spw - arg;
            end
            C_RL: begin
                for (int o = 0; o < m; o++) begin
                    cval[wi(spw + o)] = 1'b0;
                    cdirty[wi(spw + o)] = 1'b0;
                end
                spw = spw + arg;
            end
            C_RS: begin
                for (int o = m - 1; o >= 0; o--) begin
                    int w;
                    w = wi(spw + o);
                    if (!cval[w]) begin
                        push_mem(1'b0, w, 32'h0, "R8");
                        cval[w] = 1'b1; cdirty[w] = 1'b0; cdata[w] = ref_mem[w];
                    end
                end
            end
            default: ;
        endcase
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_arg   = arg[ARGW-1:0];
        cmd_wdata = wd;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic settle(input string req);
        int w;
        @(negedge clk);
        while (busy) @(negedge clk);
        w = wi(spw);
        chk(sp_out == (32'(spw) << 2), req, "stack pointer", sp_out, 32'(spw) << 2);
        chk(acc_valid == cval[w], "R9", "accumulator valid", 32'(acc_valid), 32'(cval[w]));
        if (cval[w]) chk(acc_data == cdata[w], "R9", "accumulator data", acc_data, cdata[w]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < MW; i++) begin
            mem[i]     = (32'(i) * 32'h0101_0103) ^ 32'hA500_0000;
            ref_mem[i] = (32'(i) * 32'h0101_0103) ^ 32'hA500_0000;
            cval[i]    = 1'b0;
            cdirty[i]  = 1'b0;
            cdata[i]   = '0;
        end
        spw = int'(SP0 >> 2);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(sp_out == SP0, "R1", "reset stack pointer", sp_out, SP0);
        chk(busy == 1'b0, "R1", "reset busy", 32'(busy), 32'h0);
        chk(acc_valid == 1'b0, "R1", "reset accumulator valid", 32'(acc_valid), 32'h0);

        // R2: local writes and same-cycle hits
        issue(C_WR, 0, 32'h0000_0011);
        issue(C_WR, 1, 32'h0000_0022);
        issue(C_WR, 63, 32'h0000_0063);
        issue(C_RD, 0, 32'h0);
        issue(C_RD, 63, 32'h0);
        settle("R2");

        // R3: refill of an invalid entry, then a hit on it
        issue(C_RD, 5, 32'h0);
        issue(C_RD, 5, 32'h0);
        settle("R3");

        // R4: accesses beyond the view
        issue(C_RD, 70, 32'h0);
        issue(C_WR, 80, 32'hBEEF_0080);
        issue(C_RD, 80, 32'h0);
        settle("R4");

        // R8: restore skips valid entries 0, 1 and 5
        issue(C_RS, 8, 32'h0);
        settle("R8");
        issue(C_RD, 0, 32'h0);
        issue(C_RD, 7, 32'h0);

        // R5 / R6: small allocate; only the dirty top entry is written
        issue(C_AL, 4, 32'h0);
        settle("R5");
        issue(C_WR, 0, 32'h0000_A000);
        issue(C_WR, 3, 32'h0000_A003);
        settle("R9");
        // R7: release drops the new frame
        issue(C_RL, 4, 32'h0);
        settle("R7");
        issue(C_RD, 63, 32'h0);
        issue(C_RD, 0, 32'h0);
        settle("R7");

        // R6: zero-size frame commands
        issue(C_AL, 0, 32'h0);
        settle("R6");
        issue(C_RL, 0, 32'h0);
        settle("R6");

        // R5 / R10: fully dirty view, full allocate, a write while busy is ignored
        for (int o = 0; o < DEPTH; o++) issue(C_WR, o, 32'hC000_0000 + 32'(o));
        issue(C_AL, 64, 32'h0);
        chk(busy == 1'b1, "R10", "busy during spill", 32'(busy), 32'h1);
        cmd_valid = 1'b1;
        cmd_op    = C_WR;
        cmd_arg   = '0;
        cmd_wdata = 32'hDEAD_DEAD;
        @(negedge clk);
        cmd_valid = 1'b0;
        settle("R5");
        issue(C_RD, 0, 32'h0);

        // R7 / R8: release the whole frame, restore everything, read back spilled words
        issue(C_RL, 64, 32'h0);
        settle("R7");
        issue(C_RS, 64, 32'h0);
        settle("R8");
        issue(C_RD, 0, 32'h0);
        issue(C_RD, 40, 32'h0);
        issue(C_RD, 63, 32'h0);

        // R5: allocate beyond the view size, then release it
        issue(C_WR, 10, 32'h0000_1010);
        issue(C_AL, 100, 32'h0);
        settle("R5");
        issue(C_RL, 100, 32'h0);
        settle("R7");
        issue(C_RD, 10, 32'h0);
        settle("R3");

        repeat (20) @(negedge clk);
        chk(xm_we.size() == 0, "R6", "pending memory expectations", 32'(xm_we.size()), 32'h0);
        chk(xr_data.size() == 0, "R2", "pending responses", 32'(xr_data.size()), 32'h0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule